// File: doc/BRIEF.md
# Byte-Wide Bridge to a 32-bit System Bus

This block lets an 8-bit host processor reach any byte of a 32-bit Wishbone system bus through six byte-wide registers. Four registers hold the target address, one holds the data byte, and one holds mode bits together with busy and error status. The host side is a synchronous register port with a chip select, an offset, and read and write strobes that each last one clock cycle. The bus side is a Wishbone classic master. It performs single-byte cycles and finishes each one on `ack` or `err`.

A bus cycle can be started in four ways: a write to the data register, a read of the data register, a write to the top address byte, or writing 1 to a start bit in the control register. Each of these events can also advance the address by one. When a start and an increment come from the same event, the cycle always uses the address from before the increment.

In read-on-data-read mode the bridge is pipelined. Each host read of the data register returns the byte fetched by the previous bus read and starts the next read. This lets a block of memory be streamed with one host access per byte.

Top module: `byte_bus_bridge`

## Requirements
- R1: After reset, all four address bytes, the data byte and the control byte read as 0x00, and no bus cycle is active.
- R2: Offsets 0, 1, 2 and 3 hold address bits 7:0, 15:8, 23:16 and 31:24. Each offset reads back the byte last written to it.
- R3: At offset 5, bits 5:0 are read/write mode bits. Bit 0 is write-on-data-write, bit 1 is increment-on-data-write, bit 2 is read-on-data-read, bit 3 is increment-on-data-read, bit 4 is read-on-top-byte-write, and bit 5 is increment-on-top-byte-write. When offset 5 is read, bit 6 is the error flag and bit 7 is busy. When offset 5 is written, a 1 in bit 6 starts a read and a 1 in bit 7 adds one to the address. A 0 in either bit has no effect.
- R4: A write to the data register (offset 4) always stores the byte. With mode bit 0 set, the write also starts a bus write of that byte at the current address. With mode bit 1 set, it also adds one to the full 32-bit address, carrying across all bytes. The bus write uses the address from before the increment.
- R5: A read of the data register returns the stored byte. With mode bit 2 set, the read starts a bus read at the current address, and that read updates the data register when it completes. With mode bit 3 set, the read adds one to the address after the address has been used.
- R6: A write to offset 3 replaces address bits 31:24. With mode bit 4 set, the write starts a bus read at the written top byte joined to the existing bits 23:0. With mode bit 5 set, the write adds one to bits 23:0 only, with no carry into bits 31:24.
- R7: During a cycle, `wb_sel` has exactly one bit set, the one selected by `wb_adr[1:0]`. For a write, the byte is placed on `wb_dat_o[8k+7:8k]` with k = `wb_adr[1:0]`, and the other lanes are zero. For a read, the byte is taken from the same lane of `wb_dat_i`.
- R8: Busy and `wb_cyc`/`wb_stb` go to 1 in the cycle after a start. They stay at 1, with address, write enable and select held stable, until `ack` or `err` is sampled. They return to 0 in the following cycle.
- R9: A cycle that ends with `err` sets the error flag and leaves the data register unchanged. A cycle that ends with `ack` clears the error flag.
- R10: A start that arrives while busy is 1 is ignored and launches no cycle. Register writes and address increments carried by the same event still take effect.
- R11: If a host write to the data register falls in the same cycle as the completion of a bus read, the data register keeps the host byte.
- R12: A single write of 1 to both bit 6 and bit 7 of offset 5 reads from the old address and leaves the address incremented by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the host port and the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Chip select for the register port |
| host_off | input | 3 | Register offset (0-3 address bytes, 4 data, 5 control) |
| host_rd | input | 1 | One-cycle read strobe |
| host_wr | input | 1 | One-cycle write strobe |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Byte returned to the host (combinational, zero when not reading) |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | 32 | Bus byte address |
| wb_sel | output | 4 | One-hot byte lane select |
| wb_dat_o | output | 32 | Write data, byte on its lane |
| wb_dat_i | input | 32 | Read data from the bus |
| wb_ack | input | 1 | Cycle completed normally |
| wb_err | input | 1 | Cycle completed with an error |

## Verification
The host port and the bus can both act on the data register in the same clock cycle: a host write to offset 4 can land on the cycle in which a pending bus read is acknowledged. The bench sets its bus responder to a fixed latency and counts cycles from the start strobe so that the host write strobe lands on the acknowledging edge. The case is judged correct only if the data register then reads back the host byte and not the bus byte. A second overlap is a new start arriving while a slow cycle is still busy. That case is judged by the scoreboard, which must see no extra bus cycle, and by the address, which must still have been incremented.

// File: rtl/bbb_pkg.sv
package bbb_pkg;

  localparam int MODE_W = 6;

  // mode bit positions in the control byte
  localparam int MB_WR_ON_DW  = 0;
  localparam int MB_INC_ON_DW = 1;
  localparam int MB_RD_ON_DR  = 2;
  localparam int MB_INC_ON_DR = 3;
  localparam int MB_RD_ON_TOP = 4;
  localparam int MB_INC_ON_TOP = 5;

  // trigger / status bit positions in the control byte
  localparam int CB_READ = 6;   // write: start read, read: error
  localparam int CB_INC  = 7;   // write: increment, read: busy

  typedef logic [MODE_W-1:0] mode_t;

  typedef struct packed {
    logic data_wr;
    logic data_rd;
    logic ctl_wr;
    logic top_wr;
  } host_ev_t;

endpackage

// File: rtl/bbb_host_decode.sv
module bbb_host_decode
  import bbb_pkg::*;
#(
  parameter int NB    = 4,
  parameter int OFF_W = 3
) (
  input  logic             host_cs,
  input  logic [OFF_W-1:0] host_off,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [7:0]       host_wdata,
  input  mode_t            mode_q,
  output logic [NB-1:0]    byte_wr,
  output host_ev_t         ev,
  output logic             req_start,
  output logic             req_we,
  output logic             inc_full,
  output logic             inc_low
);

  localparam logic [OFF_W-1:0] OFF_DATA = OFF_W'(NB);
  localparam logic [OFF_W-1:0] OFF_CTL  = OFF_W'(NB + 1);

  logic host_w;
  logic host_r;

  assign host_w = host_cs & host_wr;
  assign host_r = host_cs & host_rd;

  for (genvar i = 0; i < NB; i++) begin : g_byte_wr
    assign byte_wr[i] = host_w && (host_off == OFF_W'(i));
  end

  assign ev.data_wr = host_w && (host_off == OFF_DATA);
  assign ev.data_rd = host_r && (host_off == OFF_DATA);
  assign ev.ctl_wr  = host_w && (host_off == OFF_CTL);
  assign ev.top_wr  = byte_wr[NB-1];

  // each event source may request a bus cycle and/or an increment
  assign req_start = (ev.data_wr & mode_q[MB_WR_ON_DW])
                   | (ev.data_rd & mode_q[MB_RD_ON_DR])
                   | (ev.top_wr  & mode_q[MB_RD_ON_TOP])
                   | (ev.ctl_wr  & host_wdata[CB_READ]);

  assign req_we = ev.data_wr & mode_q[MB_WR_ON_DW];

  assign inc_full = (ev.data_wr & mode_q[MB_INC_ON_DW])
                  | (ev.data_rd & mode_q[MB_INC_ON_DR])
                  | (ev.ctl_wr  & host_wdata[CB_INC]);

  assign inc_low = ev.top_wr & mode_q[MB_INC_ON_TOP];

endmodule

// File: rtl/bbb_addr_reg.sv
module bbb_addr_reg #(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W/8-1:0] byte_wr,
  input  logic [7:0]         wdata,
  input  logic               inc_full,
  input  logic               inc_low,
  output logic [ADDR_W-1:0]  addr_q,
  output logic [ADDR_W-1:0]  cyc_adr
);

  localparam int NB    = ADDR_W / 8;
  localparam int LOW_W = ADDR_W - 8;

  logic [ADDR_W-1:0] addr_d;

  function automatic logic [ADDR_W-1:0] bump_full(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [LOW_W-1:0] bump_low(input logic [ADDR_W-1:0] a);
    return a[LOW_W-1:0] + LOW_W'(1);
  endfunction

  always_comb begin
    addr_d = addr_q;
    if (inc_full) addr_d = bump_full(addr_q);
    for (int i = 0; i < NB; i++) begin
      if (byte_wr[i]) addr_d[8*i +: 8] = wdata;
    end
    if (inc_low) addr_d[LOW_W-1:0] = bump_low(addr_q);
  end

  // a top-byte write targets the new top byte with the old lower bits
  assign cyc_adr = byte_wr[NB-1] ? {wdata, addr_q[LOW_W-1:0]} : addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assert_full_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_full && byte_wr == '0) |=> addr_q == $past(addr_q) + ADDR_W'(1));

  assert_top_inc_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr[NB-1] && inc_low) |=>
      (addr_q[ADDR_W-1:LOW_W] == $past(wdata)) &&
      (addr_q[LOW_W-1:0] == $past(addr_q[LOW_W-1:0]) + LOW_W'(1)));

  assert_byte_replace_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr[0] && !inc_full) |=> addr_q[7:0] == $past(wdata));

endmodule

// File: rtl/bbb_wb_master.sv
module bbb_wb_master #(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_adr,
  input  logic [7:0]        req_byte,
  input  logic              host_data_wr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        data_q,
  output logic              busy,
  output logic              err_flag,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_adr,
  output logic [BUS_W/8-1:0] wb_sel,
  output logic [BUS_W-1:0]  wb_dat_o,
  input  logic [BUS_W-1:0]  wb_dat_i,
  input  logic              wb_ack,
  input  logic              wb_err
);

  localparam int LANES  = BUS_W / 8;
  localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  // named internal events
  logic cyc_start;
  logic cyc_end_ok;
  logic cyc_end_err;
  logic rd_land;

  logic [LSEL_W-1:0] req_lane;
  logic [LANES-1:0]  req_sel;
  logic [BUS_W-1:0]  req_lanes;
  logic [7:0]        lane_pick [LANES];
  logic [7:0]        rd_byte;

  function automatic logic [LANES-1:0] lane_onehot(input logic [LSEL_W-1:0] idx);
    return LANES'(1) << idx;
  endfunction

  assign req_lane = req_adr[LSEL_W-1:0];
  assign req_sel  = lane_onehot(req_lane);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign req_lanes[8*k +: 8] = req_sel[k] ? req_byte : 8'h00;
    assign lane_pick[k]        = wb_sel[k] ? wb_dat_i[8*k +: 8] : 8'h00;
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int k = 0; k < LANES; k++) rd_byte = rd_byte | lane_pick[k];
  end

  assign cyc_start   = req_start && !wb_cyc;
  assign cyc_end_err = wb_cyc && wb_err;
  assign cyc_end_ok  = wb_cyc && wb_ack && !wb_err;
  assign rd_land     = cyc_end_ok && !wb_we;

  assign busy   = wb_cyc;
  assign wb_stb = wb_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_cyc   <= 1'b0;
      wb_we    <= 1'b0;
      wb_adr   <= '0;
      wb_sel   <= '0;
      wb_dat_o <= '0;
      err_flag <= 1'b0;
    end else if (cyc_start) begin
      wb_cyc   <= 1'b1;
      wb_we    <= req_we;
      wb_adr   <= req_adr;
      wb_sel   <= req_sel;
      wb_dat_o <= req_we ? req_lanes : '0;
    end else if (cyc_end_err) begin
      wb_cyc   <= 1'b0;
      err_flag <= 1'b1;
    end else if (cyc_end_ok) begin
      wb_cyc   <= 1'b0;
      err_flag <= 1'b0;
    end
  end

  // host write has priority over a landing read byte
  always_ff @(posedge clk) begin
    if (!rst_n)            data_q <= 8'h00;
    else if (host_data_wr) data_q <= host_wdata;
    else if (rd_land)      data_q <= rd_byte;
  end

  assert_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc |-> $countones(wb_sel) == 1);

  assert_lane_matches_adr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc |-> wb_sel[wb_adr[LSEL_W-1:0]]);

  assert_hold_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && !wb_ack && !wb_err) |=>
      wb_cyc && $stable(wb_adr) && $stable(wb_we) && $stable(wb_sel));

  assert_busy_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && (wb_ack || wb_err)) |=> !wb_cyc);

  assert_err_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_err) |=> err_flag);

  assert_err_keeps_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_err && !host_data_wr) |=> $stable(data_q));

  assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && req_start) |=> $stable(wb_adr) && $stable(wb_we));

  assert_host_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_wr |=> data_q == $past(host_wdata));

endmodule

// File: rtl/byte_bus_bridge.sv
module byte_bus_bridge
  import bbb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 32,
  localparam int NB    = ADDR_W / 8,
  localparam int OFF_W = $clog2(NB + 2),
  localparam int LANES = BUS_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs,
  input  logic [OFF_W-1:0]  host_off,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_adr,
  output logic [LANES-1:0]  wb_sel,
  output logic [BUS_W-1:0]  wb_dat_o,
  input  logic [BUS_W-1:0]  wb_dat_i,
  input  logic              wb_ack,
  input  logic              wb_err
);

  mode_t             mode_q;
  logic [NB-1:0]     byte_wr;
  host_ev_t          ev;
  logic              req_start;
  logic              req_we;
  logic              inc_full;
  logic              inc_low;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] cyc_adr;
  logic [7:0]        data_q;
  logic              busy;
  logic              err_flag;

  bbb_host_decode #(.NB(NB), .OFF_W(OFF_W)) u_decode (
    .host_cs   (host_cs),
    .host_off  (host_off),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .host_wdata(host_wdata),
    .mode_q    (mode_q),
    .byte_wr   (byte_wr),
    .ev        (ev),
    .req_start (req_start),
    .req_we    (req_we),
    .inc_full  (inc_full),
    .inc_low   (inc_low)
  );

  bbb_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_wr (byte_wr),
    .wdata   (host_wdata),
    .inc_full(inc_full),
    .inc_low (inc_low),
    .addr_q  (addr_q),
    .cyc_adr (cyc_adr)
  );

  bbb_wb_master #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_master (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_start   (req_start),
    .req_we      (req_we),
    .req_adr     (cyc_adr),
    .req_byte    (host_wdata),
    .host_data_wr(ev.data_wr),
    .host_wdata  (host_wdata),
    .data_q      (data_q),
    .busy        (busy),
    .err_flag    (err_flag),
    .wb_cyc      (wb_cyc),
    .wb_stb      (wb_stb),
    .wb_we       (wb_we),
    .wb_adr      (wb_adr),
    .wb_sel      (wb_sel),
    .wb_dat_o    (wb_dat_o),
    .wb_dat_i    (wb_dat_i),
    .wb_ack      (wb_ack),
    .wb_err      (wb_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= '0;
    else if (ev.ctl_wr) mode_q <= host_wdata[MODE_W-1:0];
  end

  always_comb begin
    host_rdata = 8'h00;
    if (host_cs && host_rd) begin
      for (int i = 0; i < NB; i++) begin
        if (host_off == OFF_W'(i)) host_rdata = addr_q[8*i +: 8];
      end
      if (host_off == OFF_W'(NB))     host_rdata = data_q;
      if (host_off == OFF_W'(NB + 1)) host_rdata = {busy, err_flag, mode_q};
    end
  end

  assert_zero_triggers_noop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_cyc && ev.ctl_wr && host_wdata[CB_INC:CB_READ] == 2'b00) |=>
      !wb_cyc && $stable(addr_q));

  assert_both_triggers_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_cyc && ev.ctl_wr && host_wdata[CB_INC:CB_READ] == 2'b11) |=>
      wb_cyc && !wb_we && (wb_adr == $past(addr_q)) &&
      (addr_q == $past(addr_q) + ADDR_W'(1)));

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !wb_cyc && addr_q == '0 && mode_q == '0);

endmodule

// File: tb/test_byte_bus_bridge.sv
module test_byte_bus_bridge;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_cs, host_rd, host_wr;
  logic [2:0]  host_off;
  logic [7:0]  host_wdata, host_rdata;
  logic        wb_cyc, wb_stb, wb_we, wb_ack, wb_err;
  logic [31:0] wb_adr, wb_dat_o, wb_dat_i;
  logic [3:0]  wb_sel;

  always #10 clk = ~clk;   // 50 MHz

  byte_bus_bridge i_byte_bus_bridge (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_off(host_off),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_sel(wb_sel), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
    .wb_ack(wb_ack), .wb_err(wb_err)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int resp_delay = 0;
  bit resp_err   = 0;
  logic [40:0] expq[$];   // {we, adr, byte}

  function automatic logic [7:0] rdbyte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'h3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic push_bus(input bit we, input logic [31:0] a, input logic [7:0] b);
    expq.push_back({we, a, b});
  endtask

  // monitor + responder: pops the expected cycle, compares, answers
  initial begin
    wb_ack = 0; wb_err = 0; wb_dat_i = '0;
    forever begin
      @(negedge clk);
      if (rst_n && wb_cyc && wb_stb && !wb_ack && !wb_err) begin
        if (expq.size() == 0) begin
          total++; bad++;
          $display("FAIL R10 unexpected bus cycle got adr=%h exp=none", wb_adr);
        end else begin
          logic [40:0] it;
          it = expq.pop_front();
          chk("R4 R5 R6 bus address", wb_adr, it[39:8]);
          chk("R4 bus write enable", {31'b0, wb_we}, {31'b0, it[40]});
          chk("R7 byte select", {28'b0, wb_sel}, {28'b0, 4'b0001 << it[9:8]});
          if (it[40])
            chk("R7 write lane", wb_dat_o, {24'b0, it[7:0]} << (8 * it[9:8]));
        end
        repeat (resp_delay) @(negedge clk);
        for (int k = 0; k < 4; k++)
          wb_dat_i[8*k +: 8] = (k == int'(wb_adr[1:0])) ? rdbyte(wb_adr) : 8'hEE;
        wb_ack = !resp_err;
        wb_err = resp_err;
        @(negedge clk);
        wb_ack = 0; wb_err = 0;
      end
    end
  end

  // host tasks: entered at a falling edge, leave at the next falling edge
  task automatic hwr(input int off, input logic [7:0] d);
    host_cs = 1; host_wr = 1; host_off = 3'(off); host_wdata = d;
    @(negedge clk);
    host_cs = 0; host_wr = 0;
  endtask

  task automatic hrd(input int off, output logic [7:0] d);
    host_cs = 1; host_rd = 1; host_off = 3'(off);
    #1 d = host_rdata;
    @(negedge clk);
    host_cs = 0; host_rd = 0;
  endtask

  task automatic set_addr(input logic [31:0] a);
    for (int i = 0; i < 4; i++) hwr(i, a[8*i +: 8]);
  endtask

  task automatic get_addr(output logic [31:0] a);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin hrd(i, b); a[8*i +: 8] = b; end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (wb_cyc) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [31:0] a;
    rst_n = 0; host_cs = 0; host_rd = 0; host_wr = 0; host_off = 0; host_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 6; i++) begin hrd(i, d); chk("R1 reset register", {24'b0, d}, 32'h0); end
    chk("R1 no cycle after reset", {31'b0, wb_cyc}, 32'h0);

    // R2 address bytes little-endian
    set_addr(32'h12345678);
    get_addr(a);
    chk("R2 address readback", a, 32'h12345678);

    // R3 mode bits read back, zero triggers do nothing
    hwr(5, 8'h3F);
    hrd(5, d);
    chk("R3 mode readback", {24'b0, d}, 32'h3F);
    get_addr(a);
    chk("R3 zero trigger keeps address", a, 32'h12345678);
    hwr(5, 8'h00);

    // R4 write on data write with increment
    hwr(5, 8'h03);
    push_bus(1, 32'h12345678, 8'hA5);
    hwr(4, 8'hA5);
    wait_idle();
    get_addr(a);
    chk("R4 post-increment", a, 32'h12345679);
    hrd(4, d);
    chk("R4 data stored", {24'b0, d}, 32'hA5);
    set_addr(32'h1234FFFF);
    push_bus(1, 32'h1234FFFF, 8'h3C);
    hwr(4, 8'h3C);
    wait_idle();
    get_addr(a);
    chk("R4 full carry", a, 32'h12350000);

    // R5 pipelined read on data read
    hwr(5, 8'h00);
    set_addr(32'h00000100);
    push_bus(0, 32'h100, 0);
    hwr(5, 8'h4C);
    wait_idle();
    push_bus(0, 32'h100, 0);
    hrd(4, d);
    chk("R5 first read returns earlier fetch", {24'b0, d}, {24'b0, rdbyte(32'h100)});
    wait_idle();
    push_bus(0, 32'h101, 0);
    hrd(4, d);
    chk("R5 second read lags one", {24'b0, d}, {24'b0, rdbyte(32'h100)});
    wait_idle();
    hwr(5, 8'h00);
    hrd(4, d);
    chk("R5 third read", {24'b0, d}, {24'b0, rdbyte(32'h101)});
    get_addr(a);
    chk("R5 address advanced", a, 32'h102);

    // R6 top byte write: read and low-24 increment without carry
    set_addr(32'h11FFFFFF);
    hwr(5, 8'h30);
    push_bus(0, 32'hABFFFFFF, 0);
    hwr(3, 8'hAB);
    wait_idle();
    get_addr(a);
    chk("R6 no carry into top byte", a, 32'hAB000000);
    hrd(4, d);
    chk("R7 R6 read lane 3", {24'b0, d}, {24'b0, rdbyte(32'hABFFFFFF)});
    hwr(5, 8'h00);

    // R9 error handling
    resp_err = 1;
    push_bus(0, 32'hAB000000, 0);
    hwr(5, 8'h40);
    wait_idle();
    hrd(5, d);
    chk("R9 error flag set", {24'b0, d}, 32'h40);
    hrd(4, d);
    chk("R9 data unchanged on error", {24'b0, d}, {24'b0, rdbyte(32'hABFFFFFF)});
    resp_err = 0;
    push_bus(0, 32'hAB000000, 0);
    hwr(5, 8'h40);
    wait_idle();
    hrd(5, d);
    chk("R9 error cleared by ack", {24'b0, d}, 32'h00);
    hrd(4, d);
    chk("R7 read lane 0", {24'b0, d}, {24'b0, rdbyte(32'hAB000000)});

    // R8 busy, R10 start ignored while busy
    resp_delay = 4;
    set_addr(32'h40);
    push_bus(0, 32'h40, 0);
    hwr(5, 8'h40);
    hrd(5, d);
    chk("R8 busy during cycle", {24'b0, d}, 32'h80);
    hwr(5, 8'hC0);
    wait_idle();
    get_addr(a);
    chk("R10 increment applied while busy", a, 32'h41);
    hrd(5, d);
    chk("R8 busy cleared", {24'b0, d}, 32'h00);
    hrd(4, d);
    chk("R10 running cycle result", {24'b0, d}, {24'b0, rdbyte(32'h40)});

    // R11 host write collides with read completion
    resp_delay = 2;
    set_addr(32'h50);
    push_bus(0, 32'h50, 0);
    hwr(5, 8'h40);
    repeat (2) @(negedge clk);
    hwr(4, 8'h77);
    wait_idle();
    hrd(4, d);
    chk("R11 host byte wins", {24'b0, d}, 32'h77);

    // R12 both trigger bits in one write
    resp_delay = 0;
    set_addr(32'h20000003);
    push_bus(0, 32'h20000003, 0);
    hwr(5, 8'hC0);
    wait_idle();
    get_addr(a);
    chk("R12 address incremented", a, 32'h20000004);
    hrd(4, d);
    chk("R12 read old address", {24'b0, d}, {24'b0, rdbyte(32'h20000003)});

    chk("R10 no pending expected cycles", expq.size(), 0);
    done = 1;
    summary();
    $finish;
  end

endmodule